// File: doc/BRIEF.md
# Four-Group Carry Lookahead Generator

This block looks ahead across four adder groups or ALU slices and works out, all at once, the carry into each of groups 1, 2 and 3. It does not wait for a carry to ripple through the groups. Each group supplies one generate signal and one propagate signal, both active-low. The block also takes one active-high carry-in. It has no clock and no storage, so every output is a function of the present inputs alone.

Besides the three carries, the block drives a combined generate and propagate pair for all four groups, again active-low. That pair lets one unit act as a single "super group" for a unit one level up. A second-level unit that takes the block pairs of four first-level units anticipates carries across sixteen groups. Because the polarities match on input and output, units connect to each other and to the slices without inverters. There is no carry-out of the fourth group: that carry is formed one level up from the block pair.

Top module: `cla_gen4`

## Requirements
- R1: Bit i of `grp_gen_n` and bit i of `grp_prop_n` belong to group i (0 to 3), and a 0 on a bit asserts it. When no group generates, no group propagates and `carry_in` is 0, all three carries are 0 and both block outputs are 1.
- R2: `carry_g1` = g0 | (p0 & `carry_in`), with g and p taken active-high.
- R3: `carry_g2` = g1 | (p1 & g0) | (p1 & p0 & `carry_in`).
- R4: `carry_g3` = g2 | (p2 & g1) | (p2 & p1 & g0) | (p2 & p1 & p0 & `carry_in`).
- R5: `blk_gen_n` is 0 exactly when g3 | (p3 & g2) | (p3 & p2 & g1) | (p3 & p2 & p1 & g0) holds. It is independent of `carry_in`.
- R6: `blk_prop_n` is 0 exactly when all four groups propagate.
- R7: All outputs settle from the present inputs with no clock edge. An input change is seen at the outputs without any clock edge.
- R8: Five units wired as a two-level tree over sixteen 4-bit slices give the correct carry into every slice of a 64-bit addition. In that tree, first-level unit j serves slices 4j to 4j+3, and its carry-in is the second-level carry into slice 4j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| grp_gen_n | input | 4 | Group generate, active-low, bit i = group i |
| grp_prop_n | input | 4 | Group propagate, active-low, bit i = group i |
| carry_in | input | 1 | Carry into group 0, active-high |
| carry_g1 | output | 1 | Anticipated carry into group 1, active-high |
| carry_g2 | output | 1 | Anticipated carry into group 2, active-high |
| carry_g3 | output | 1 | Anticipated carry into group 3, active-high |
| blk_gen_n | output | 1 | Generate of the four-group block, active-low |
| blk_prop_n | output | 1 | Propagate of the four-group block, active-low |

## Verification
All 512 combinations of the nine inputs are applied and compared with a ripple-carry model. This separates a wrong product term, a swapped group index or an inverted polarity from the correct sums of products. It also shows that the block outputs ignore the carry-in. Directed patterns add further checks:
- a fully idle input set;
- a carry-in that must travel through all propagating groups;
- a generate in group 3 that must dominate.

Random 64-bit operand pairs, including all-ones plus one, drive a five-unit tree. The carry into every slice is compared with true addition, which confirms that the block pair cascades correctly.

// File: rtl/cla_gen4.sv
module cla_gen4 (
  input  logic [3:0] grp_gen_n,
  input  logic [3:0] grp_prop_n,
  input  logic       carry_in,
  output logic       carry_g1,
  output logic       carry_g2,
  output logic       carry_g3,
  output logic       blk_gen_n,
  output logic       blk_prop_n
);

  logic [3:0] g, p;
  logic       bg;

  assign g = ~grp_gen_n;
  assign p = ~grp_prop_n;

  assign carry_g1 = g[0] | (p[0] & carry_in);
  assign carry_g2 = g[1] | (p[1] & g[0]) | (p[1] & p[0] & carry_in);
  assign carry_g3 = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                  | (p[2] & p[1] & p[0] & carry_in);

  assign bg = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
            | (p[3] & p[2] & p[1] & g[0]);

  assign blk_gen_n  = ~bg;
  assign blk_prop_n = ~(&p);

  always_comb begin
    // R1
    idle_quiet_chk: assert (!(grp_gen_n == 4'hF && grp_prop_n == 4'hF && !carry_in)
                            || (!carry_g1 && !carry_g2 && !carry_g3 && blk_gen_n && blk_prop_n));
    // R2
    g1_from_gen0_chk: assert (grp_gen_n[0] || carry_g1);
    // R4
    g3_full_chain_chk: assert (!(carry_in && grp_prop_n == 4'h0) || carry_g3);
    // R5
    blk_gen_source_chk: assert (blk_gen_n || grp_gen_n != 4'hF);
    // R6
    blk_prop_all_chk: assert (blk_prop_n || grp_prop_n == 4'h0);
  end

endmodule

// File: tb/cla_gen4_test.sv
module cla_gen4_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [3:0] gn, pn;
  logic       ci;
  logic       c1, c2, c3, bgn, bpn;

  cla_gen4 uut (
    .grp_gen_n(gn), .grp_prop_n(pn), .carry_in(ci),
    .carry_g1(c1), .carry_g2(c2), .carry_g3(c3),
    .blk_gen_n(bgn), .blk_prop_n(bpn)
  );

  // two-level tree for R8
  logic [15:0] sg_n, sp_n;
  logic        top_ci;
  logic [3:0]  l1_ci, l1_bg, l1_bp, l1_x, l1_y, l1_z;
  logic        l2_x, l2_y, l2_z, l2_bg, l2_bp;

  assign l1_ci = {l2_z, l2_y, l2_x, top_ci};

  for (genvar j = 0; j < 4; j++) begin : g_l1
    cla_gen4 u1 (
      .grp_gen_n(sg_n[4*j +: 4]), .grp_prop_n(sp_n[4*j +: 4]), .carry_in(l1_ci[j]),
      .carry_g1(l1_x[j]), .carry_g2(l1_y[j]), .carry_g3(l1_z[j]),
      .blk_gen_n(l1_bg[j]), .blk_prop_n(l1_bp[j])
    );
  end

  cla_gen4 u2 (
    .grp_gen_n(l1_bg), .grp_prop_n(l1_bp), .carry_in(top_ci),
    .carry_g1(l2_x), .carry_g2(l2_y), .carry_g3(l2_z),
    .blk_gen_n(l2_bg), .blk_prop_n(l2_bp)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b (g_n=%b p_n=%b cin=%b)",
               req, what, act, exp, gn, pn, ci);
    end
  endtask

  // ripple reference: carries into groups 1..3 and block pair (active-high)
  task automatic ref_model(input logic [3:0] g, input logic [3:0] p, input logic c0,
                           output logic [3:1] cr, output logic bg, output logic bp);
    logic c;
    c = c0;
    for (int i = 0; i < 3; i++) begin
      c = g[i] | (p[i] & c);
      cr[i+1] = c;
    end
    c = 1'b0;
    for (int i = 0; i < 4; i++) c = g[i] | (p[i] & c);
    bg = c;
    bp = &p;
  endtask

  task automatic apply(input logic [3:0] g_n, input logic [3:0] p_n, input logic c);
    @(negedge clk);
    gn = g_n; pn = p_n; ci = c;
    #1;
  endtask

  task automatic test_idle();
    apply(4'hF, 4'hF, 1'b0);
    chk("R1", c1, 1'b0, "idle carry_g1");
    chk("R1", c2, 1'b0, "idle carry_g2");
    chk("R1", c3, 1'b0, "idle carry_g3");
    chk("R1", bgn, 1'b1, "idle blk_gen_n");
    chk("R1", bpn, 1'b1, "idle blk_prop_n");
  endtask

  task automatic test_directed();
    apply(4'hF, 4'h0, 1'b1);
    chk("R4", c3, 1'b1, "carry through all propagates");
    chk("R6", bpn, 1'b0, "all propagate");
    chk("R5", bgn, 1'b1, "propagate only, no block generate");
    apply(4'h7, 4'hF, 1'b0);
    chk("R5", bgn, 1'b0, "group 3 generate");
    chk("R3", c2, 1'b0, "group 3 generate no effect on carry_g2");
    // R7: change input without any clock edge
    gn = 4'hE; pn = 4'hF; ci = 1'b0;
    #0.5;
    chk("R7", c1, 1'b1, "output follows input without clock");
    apply(4'hF, 4'hE, 1'b1);
    chk("R2", c1, 1'b1, "cin through p0");
    chk("R3", c2, 1'b0, "p1 not set blocks carry_g2");
  endtask

  task automatic test_sweep();
    logic [3:1] cr;
    logic bg, bp;
    for (int v = 0; v < 512; v++) begin
      apply(v[3:0], v[7:4], v[8]);
      ref_model(~v[3:0], ~v[7:4], v[8], cr, bg, bp);
      chk("R2", c1, cr[1], "sweep carry_g1");
      chk("R3", c2, cr[2], "sweep carry_g2");
      chk("R4", c3, cr[3], "sweep carry_g3");
      chk("R5", bgn, ~bg, "sweep blk_gen_n");
      chk("R6", bpn, ~bp, "sweep blk_prop_n");
    end
  endtask

  task automatic add64(input logic [63:0] a, input logic [63:0] b, input logic c);
    logic [64:0] s;
    logic [63:0] cin_vec;
    logic [3:0] got;
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      logic [4:0] t;
      t = {1'b0, a[4*k +: 4]} + {1'b0, b[4*k +: 4]};
      sg_n[k] = ~t[4];
      sp_n[k] = ~(t[3:0] == 4'hF);
    end
    top_ci = c;
    #1;
    s = {1'b0, a} + {1'b0, b} + {64'd0, c};
    cin_vec = s[63:0] ^ a ^ b;
    for (int k = 1; k < 16; k++) begin
      logic act;
      if (k % 4 == 0) act = l1_ci[k/4];
      else if (k % 4 == 1) act = l1_x[k/4];
      else if (k % 4 == 2) act = l1_y[k/4];
      else act = l1_z[k/4];
      total++;
      if (act !== cin_vec[4*k]) begin
        bad++;
        $display("FAIL R8 slice %0d carry: actual=%b expected=%b (a=%h b=%h cin=%b)",
                 k, act, cin_vec[4*k], a, b, c);
      end
    end
    got = {1'b0, 1'b0, l2_bp, l2_bg};
    total++;
    if ((~got[0] | (~got[1] & c)) !== s[64]) begin
      bad++;
      $display("FAIL R8 carry out: actual=%b expected=%b", ~got[0] | (~got[1] & c), s[64]);
    end
  endtask

  task automatic test_cascade();
    add64(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);
    add64(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1);
    add64(64'h0F0F_F0F0_1234_8000, 64'h00F0_0F10_EDCB_8000, 1'b0);
    add64(64'd0, 64'd0, 1'b0);
    for (int r = 0; r < 200; r++)
      add64({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
  endtask

  initial begin
    #20000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    gn = 4'hF; pn = 4'hF; ci = 1'b0;
    sg_n = '1; sp_n = '1; top_ci = 1'b0;
    repeat (2) @(posedge clk);
    test_idle();
    test_directed();
    test_sweep();
    test_cascade();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule